// File: doc/BRIEF.md
# Core Memory Cycle Timing Controller

This block sequences one read-then-write cycle of a coincident-current magnetic core memory. A requester asks for a cycle by raising the master clock pulse and the cycle enable together. The controller then runs a fixed series of phase strobes: read drive, sense strobe, write drive or write inhibit, and a recovery interval. New requests are refused until that series has ended. The drive switches, the core array and the sense amplifiers are not part of the block. Each of them is represented by a plain digital strobe or input.

Phase lengths are parameters that take the place of delay-line taps. The read-restore and clear-write modes share exactly the same timing. In clear-write mode the sense strobe is blanked, so no data reaches the output. During the write phase the data bit chooses between driving the line and inhibiting it, and inhibiting the line stores a zero. The mode and the data bit are captured when a cycle is accepted. Busy is the OR of the running control flip-flop and a separate recovery flag.

Top module: `core_cycle_ctrl`

## Requirements
- R1: A cycle starts only when `mclk_pulse` and `cycle_en` are both high at the same rising edge while the controller is idle. From the next cycle `read_drive` and `busy` are high. Either input alone does nothing.
- R2: A request sampled while busy, at any edge other than the one that ends the final recovery cycle, is dropped. It changes neither the strobes nor the cycle length, and no cycle follows it.
- R3: A request sampled at the edge that ends the final recovery cycle is accepted. `busy` stays high and `read_drive` is high in the very next cycle.
- R4: After acceptance the phases run in a fixed order. Read lasts READ_LEN cycles, sense lasts SENSE_LEN, write lasts WRITE_LEN and recovery lasts RECOV_LEN. `busy` is high for exactly their sum and then drops.
- R5: During the write phase `write_drive` is high when the captured data bit is 1, and `write_inhibit` is high when it is 0.
- R6: With `mode_rr`=0 (clear-write) the phase timing is identical to read-restore. However, `sense_strobe` and `data_valid` stay low and `data_out` keeps its previous value.
- R7: With `mode_rr`=1 (read-restore), `data_out` takes the value of `sense_in` present in the last sense cycle. `data_valid` pulses for one cycle, which is the first write cycle.
- R8: `mode_rr` and `data_in` are captured at acceptance. Changing them later in the cycle has no effect on that cycle.
- R9: Synchronous reset returns the controller to idle. `busy`, all strobes, `data_valid` and `data_out` are 0, including when reset interrupts a running cycle.
- R10: The four strobes are never high together in any combination of two or more. During recovery `busy` is high with all strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mclk_pulse | input | 1 | Master clock pulse, half of a cycle request |
| cycle_en | input | 1 | Memory cycle enable, other half of a request |
| mode_rr | input | 1 | 1 = read-restore, 0 = clear-write |
| data_in | input | 1 | Bit to be written in the write phase |
| sense_in | input | 1 | Sense-amplifier output of the selected core |
| read_drive | output | 1 | Read drive strobe |
| sense_strobe | output | 1 | Sense strobe, read-restore only |
| write_drive | output | 1 | Write drive strobe, data bit 1 |
| write_inhibit | output | 1 | Inhibit strobe, data bit 0 |
| busy | output | 1 | Cycle in progress |
| data_valid | output | 1 | One-cycle pulse when `data_out` has been refreshed |
| data_out | output | 1 | Last sensed data bit |

## Verification
Let edge k be the edge that accepts a request, and let L be the sum of the four phase lengths. Every strobe and `busy` is then due in the cycle after edges k through k+L-1, and the phase is given by the offset from k. `data_valid` and the new `data_out` are due after edge k+READ_LEN+SENSE_LEN. Idle is due after edge k+L, or a new read phase when a request was chained at that edge. The bench drives at the falling edge and, one falling edge after each rising edge, compares every output against the value computed from that offset. This covers every mode, data and sense combination, as well as dropped, chained, altered-mid-cycle and reset-interrupted cycles.

// File: rtl/core_cycle_pkg.sv
package core_cycle_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_READ  = 3'd1,
        PH_SENSE = 3'd2,
        PH_WRITE = 3'd3,
        PH_RECOV = 3'd4
    } phase_e;

    typedef struct packed {
        logic read_drive;
        logic sense_strobe;
        logic write_drive;
        logic write_inhibit;
    } strobe_t;

    typedef struct packed {
        logic restore;
        logic data;
    } cyc_cfg_t;

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/ccc_phase_seq.sv
module ccc_phase_seq
    import core_cycle_pkg::*;
#(
    parameter int READ_LEN  = 3,
    parameter int SENSE_LEN = 2,
    parameter int WRITE_LEN = 3,
    parameter int RECOV_LEN = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     req,
    input  cyc_cfg_t cfg_in,
    output phase_e   phase,
    output logic     phase_last,
    output logic     busy,
    output cyc_cfg_t cfg_hold
);
    localparam int MAXLEN = max4(READ_LEN, SENSE_LEN, WRITE_LEN, RECOV_LEN);
    localparam int CW     = $clog2(MAXLEN + 1);
    localparam logic [CW-1:0] R_M1 = CW'(READ_LEN - 1);
    localparam logic [CW-1:0] S_M1 = CW'(SENSE_LEN - 1);
    localparam logic [CW-1:0] W_M1 = CW'(WRITE_LEN - 1);
    localparam logic [CW-1:0] V_M1 = CW'(RECOV_LEN - 1);

    phase_e        phase_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] len_m1;
    logic          run_ff;
    logic          recov_ff;
    logic          recov_end;
    logic          start;

    always_comb begin
        case (phase_q)
            PH_READ:  len_m1 = R_M1;
            PH_SENSE: len_m1 = S_M1;
            PH_WRITE: len_m1 = W_M1;
            PH_RECOV: len_m1 = V_M1;
            default:  len_m1 = '0;
        endcase
    end

    assign phase_last = (phase_q != PH_IDLE) && (cnt_q == len_m1);
    assign busy       = run_ff | recov_ff;
    assign recov_end  = recov_ff && phase_last;
    assign start      = req && (!busy || recov_end);
    assign phase      = phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_IDLE;
            cnt_q    <= '0;
            run_ff   <= 1'b0;
            recov_ff <= 1'b0;
            cfg_hold <= '0;
        end else if (start) begin
            phase_q  <= PH_READ;
            cnt_q    <= '0;
            run_ff   <= 1'b1;
            recov_ff <= 1'b0;
            cfg_hold <= cfg_in;
        end else if (busy) begin
            if (phase_last) begin
                cnt_q <= '0;
                case (phase_q)
                    PH_READ:  phase_q <= PH_SENSE;
                    PH_SENSE: phase_q <= PH_WRITE;
                    PH_WRITE: begin
                        phase_q  <= PH_RECOV;
                        run_ff   <= 1'b0;
                        recov_ff <= 1'b1;
                    end
                    default: begin
                        phase_q  <= PH_IDLE;
                        run_ff   <= 1'b0;
                        recov_ff <= 1'b0;
                    end
                endcase
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/ccc_strobe_dec.sv
module ccc_strobe_dec
    import core_cycle_pkg::*;
(
    input  phase_e   phase,
    input  cyc_cfg_t cfg,
    output strobe_t  strb
);
    always_comb begin
        strb = '0;
        case (phase)
            PH_READ:  strb.read_drive = 1'b1;
            PH_SENSE: strb.sense_strobe = cfg.restore;
            PH_WRITE: begin
                strb.write_drive   = cfg.data;
                strb.write_inhibit = !cfg.data;
            end
            default: strb = '0;
        endcase
    end
endmodule

// File: rtl/ccc_sense_cap.sv
module ccc_sense_cap (
    input  logic clk,
    input  logic rst,
    input  logic capture,
    input  logic sense_in,
    output logic data_out,
    output logic data_valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data_out   <= 1'b0;
            data_valid <= 1'b0;
        end else begin
            data_valid <= capture;
            if (capture) data_out <= sense_in;
        end
    end
endmodule

// File: rtl/core_cycle_ctrl.sv
module core_cycle_ctrl
    import core_cycle_pkg::*;
#(
    parameter int READ_LEN  = 3,
    parameter int SENSE_LEN = 2,
    parameter int WRITE_LEN = 3,
    parameter int RECOV_LEN = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic mclk_pulse,
    input  logic cycle_en,
    input  logic mode_rr,
    input  logic data_in,
    input  logic sense_in,
    output logic read_drive,
    output logic sense_strobe,
    output logic write_drive,
    output logic write_inhibit,
    output logic busy,
    output logic data_valid,
    output logic data_out
);
    phase_e   phase;
    logic     phase_last;
    logic     req_w;
    logic     cap_w;
    cyc_cfg_t cfg_in;
    cyc_cfg_t cfg_q;
    strobe_t  strb;

    assign req_w          = mclk_pulse & cycle_en;
    assign cfg_in.restore = mode_rr;
    assign cfg_in.data    = data_in;

    ccc_phase_seq #(
        .READ_LEN (READ_LEN),
        .SENSE_LEN(SENSE_LEN),
        .WRITE_LEN(WRITE_LEN),
        .RECOV_LEN(RECOV_LEN)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req       (req_w),
        .cfg_in    (cfg_in),
        .phase     (phase),
        .phase_last(phase_last),
        .busy      (busy),
        .cfg_hold  (cfg_q)
    );

    ccc_strobe_dec u_dec (
        .phase(phase),
        .cfg  (cfg_q),
        .strb (strb)
    );

    assign cap_w = (phase == PH_SENSE) && phase_last && cfg_q.restore;

    ccc_sense_cap u_cap (
        .clk       (clk),
        .rst       (rst),
        .capture   (cap_w),
        .sense_in  (sense_in),
        .data_out  (data_out),
        .data_valid(data_valid)
    );

    assign read_drive    = strb.read_drive;
    assign sense_strobe  = strb.sense_strobe;
    assign write_drive   = strb.write_drive;
    assign write_inhibit = strb.write_inhibit;

endmodule

// File: rtl/ccc_checker.sv
module ccc_checker (
    input logic clk,
    input logic rst,
    input logic mclk_pulse,
    input logic cycle_en,
    input logic read_drive,
    input logic sense_strobe,
    input logic write_drive,
    input logic write_inhibit,
    input logic busy,
    input logic data_valid,
    input logic hold_restore,
    input logic hold_data
);
    a_r1_start: assert property (@(posedge clk) disable iff (rst)
        (!busy && mclk_pulse && cycle_en) |=> (busy && read_drive));

    a_r1_no_request_stays_idle: assert property (@(posedge clk) disable iff (rst)
        (!busy && !(mclk_pulse && cycle_en)) |=> !busy);

    a_r10_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({read_drive, sense_strobe, write_drive, write_inhibit}));

    a_r10_strobe_needs_busy: assert property (@(posedge clk) disable iff (rst)
        (read_drive || sense_strobe || write_drive || write_inhibit) |-> busy);

    a_r5_drive_on_one: assert property (@(posedge clk) disable iff (rst)
        write_drive |-> hold_data);

    a_r5_inhibit_on_zero: assert property (@(posedge clk) disable iff (rst)
        write_inhibit |-> !hold_data);

    a_r6_clear_write_quiet: assert property (@(posedge clk) disable iff (rst)
        !hold_restore |-> (!sense_strobe && !data_valid));

    a_r7_valid_after_sense: assert property (@(posedge clk) disable iff (rst)
        data_valid |-> ($past(sense_strobe) && !sense_strobe));
endmodule

bind core_cycle_ctrl ccc_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .mclk_pulse   (mclk_pulse),
    .cycle_en     (cycle_en),
    .read_drive   (read_drive),
    .sense_strobe (sense_strobe),
    .write_drive  (write_drive),
    .write_inhibit(write_inhibit),
    .busy         (busy),
    .data_valid   (data_valid),
    .hold_restore (cfg_q.restore),
    .hold_data    (cfg_q.data)
);

// File: tb/test_core_cycle_ctrl.sv
`timescale 1ns/1ps
module test_core_cycle_ctrl;
    localparam int RL = 2;
    localparam int SL = 1;
    localparam int WL = 2;
    localparam int VL = 2;
    localparam int L  = RL + SL + WL + VL;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mclk_pulse = 1'b0;
    logic cycle_en = 1'b0;
    logic mode_rr = 1'b0;
    logic data_in = 1'b0;
    logic sense_in = 1'b0;
    logic read_drive, sense_strobe, write_drive, write_inhibit, busy, data_valid, data_out;

    int   checks = 0;
    int   fails = 0;
    logic exp_dout = 1'b0;
    bit   done = 1'b0;

    core_cycle_ctrl #(
        .READ_LEN(RL), .SENSE_LEN(SL), .WRITE_LEN(WL), .RECOV_LEN(VL)
    ) i_core_cycle_ctrl (
        .clk(clk), .rst(rst), .mclk_pulse(mclk_pulse), .cycle_en(cycle_en),
        .mode_rr(mode_rr), .data_in(data_in), .sense_in(sense_in),
        .read_drive(read_drive), .sense_strobe(sense_strobe),
        .write_drive(write_drive), .write_inhibit(write_inhibit),
        .busy(busy), .data_valid(data_valid), .data_out(data_out)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string rq, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", rq, what, act, exp, $time);
        end
    endtask

    task automatic check_idle(input string rq);
        chk(rq, "busy", busy, 1'b0);
        chk(rq, "read_drive", read_drive, 1'b0);
        chk(rq, "sense_strobe", sense_strobe, 1'b0);
        chk(rq, "write_drive", write_drive, 1'b0);
        chk(rq, "write_inhibit", write_inhibit, 1'b0);
        chk(rq, "data_valid", data_valid, 1'b0);
        chk(rq, "data_out", data_out, exp_dout);
    endtask

    // m: mode, d: data bit, s: sense value, flip: alter mode/data after start,
    // spam: requests while busy, chain: request at the final recovery edge
    task automatic run_cycle(input logic m, input logic d, input logic s,
                             input bit flip, input bit spam, input bit chain);
        @(negedge clk);
        mode_rr = m; data_in = d; sense_in = s;
        mclk_pulse = 1'b1; cycle_en = 1'b1;
        for (int j = 0; j < L; j++) begin
            @(negedge clk);
            mclk_pulse = 1'b0; cycle_en = 1'b0;
            if (m && j == RL + SL) exp_dout = s;
            // R4 phase timing, R5 write gating, R6/R7 sense behaviour
            chk("R4", "busy", busy, 1'b1);
            chk("R4", "read_drive", read_drive, j < RL);
            chk(m ? "R7" : "R6", "sense_strobe", sense_strobe,
                m && (j >= RL) && (j < RL + SL));
            chk("R5", "write_drive", write_drive,
                d && (j >= RL + SL) && (j < RL + SL + WL));
            chk("R5", "write_inhibit", write_inhibit,
                !d && (j >= RL + SL) && (j < RL + SL + WL));
            chk(m ? "R7" : "R6", "data_valid", data_valid, m && (j == RL + SL));
            chk(m ? "R7" : "R6", "data_out", data_out, exp_dout);
            if (flip && j == 0) begin
                mode_rr = !m; data_in = !d;   // R8: must not affect this cycle
            end
            if (spam && j < L - 1) begin
                mclk_pulse = 1'b1; cycle_en = 1'b1;   // R2: dropped
            end
            if (chain && j == L - 1) begin
                mclk_pulse = 1'b1; cycle_en = 1'b1;   // R3: accepted
            end
        end
        @(negedge clk);
        mclk_pulse = 1'b0; cycle_en = 1'b0;
        if (chain) begin
            chk("R3", "busy", busy, 1'b1);
            chk("R3", "read_drive", read_drive, 1'b1);
            repeat (L) @(negedge clk);
            check_idle("R3");
        end else begin
            check_idle(spam ? "R2" : (flip ? "R8" : "R4"));
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_idle("R9");
        rst = 1'b0;
        @(negedge clk);
        check_idle("R9");

        // R1: each half of a request alone does nothing
        mclk_pulse = 1'b1;
        repeat (3) begin @(negedge clk); check_idle("R1"); end
        mclk_pulse = 1'b0; cycle_en = 1'b1;
        repeat (3) begin @(negedge clk); check_idle("R1"); end
        cycle_en = 1'b0;

        // sweep of mode, data and sense
        for (int v = 0; v < 8; v++) begin
            run_cycle(v[2], v[1], v[0], 1'b0, 1'b0, 1'b0);
        end

        // R8: inputs changed mid-cycle
        run_cycle(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        run_cycle(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        run_cycle(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);

        // R2: requests while busy are dropped
        run_cycle(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        run_cycle(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);

        // R3: back-to-back acceptance
        run_cycle(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        run_cycle(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);

        // R9: reset interrupting a cycle
        run_cycle(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R9", "data_out before reset", data_out, 1'b1);
        @(negedge clk);
        mode_rr = 1'b1; data_in = 1'b1; mclk_pulse = 1'b1; cycle_en = 1'b1;
        repeat (3) @(negedge clk);
        mclk_pulse = 1'b0; cycle_en = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        exp_dout = 1'b0;
        check_idle("R9");
        rst = 1'b0;
        repeat (2) begin @(negedge clk); check_idle("R9"); end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule